// File: doc/BRIEF.md
# Paravirtual Device Control Register File

This block is the register front end of a paravirtualized I/O device. A host-side driver reaches it through a simple 32-bit register bus: an address, a write strobe with write data, and a read strobe whose data comes back on the next cycle. The block returns fixed identification words. It exposes the device's feature bitmap one 32-bit slice at a time and collects the features the driver accepts. It keeps the setup of every virtqueue (size, ready flag, and the 64-bit addresses of the descriptor table, available ring and used ring). It also holds a device status byte, a configuration generation counter and a two-cause interrupt status with acknowledge.

Much of the map is indirect. A selector register picks which feature slice or which queue a later access refers to, so one offset can reach different storage. The device side raises interrupt causes with one-cycle event inputs. It reads any queue's setup through its own lookup port. It receives queue notifications as a one-cycle valid pulse that carries the queue index. The notification path has no ready signal: the device side must accept a pulse in the cycle it appears, and the bus never stalls. Writing zero to the device status register is a device reset. It clears all queue setup, the accepted features and the interrupt status.

Top module: `pvdev_regfile`

## Requirements
- R1: Reads of offset 0x000 return 0x74726976. Offset 0x004 returns the version, 0x008 the device ID and 0x00C the vendor ID (parameters). Bus writes to these offsets change none of them.
- R2: A read of 0x010 returns the 32-bit slice of the device feature bitmap whose number was last written to 0x014 (slice 0 holds bits 31:0). A slice number at or beyond the slice count reads as zero.
- R3: A write to 0x020 stores the value into the accepted-feature slice chosen by the number last written to 0x024, and the result is visible on `drv_features`. When that number is out of range, the write is ignored.
- R4: The value written to 0x030 selects a queue. For that queue, 0x034 reads the maximum queue size and 0x044 bit 0 is the ready flag. The ring addresses are read/write 32-bit halves: descriptor table at 0x080 (low) and 0x084 (high), available ring at 0x090 and 0x094, used ring at 0x0A0 and 0x0A4. With a selector at or beyond the queue count, all of these read zero and writes to them are ignored.
- R5: A write to 0x038 sets the selected queue's size. The offset reads zero. Size, ready and ring addresses of the queue named by `dev_q_idx` appear on the `dev_q_*` outputs.
- R6: Interrupt status at 0x060 has bit 0 (used ring updated), set by `dev_used_evt`, and bit 1 (configuration changed), set by `dev_cfg_evt`. `irq_o` is high while any bit is set.
- R7: A write to 0x064 clears every status bit that is 1 in the written value. When an event and an acknowledge hit the same bit in one cycle, the bit stays set.
- R8: A write to 0x050 makes `notify_valid` high for exactly the next cycle, with `notify_qidx` holding the low bits of the written value.
- R9: Offset 0x070 is a read/write device status byte, driven on `dev_status`. Writing the word zero also clears every queue's ready flag, size and ring addresses, the accepted features and the interrupt status.
- R10: Offset 0x0FC reads a generation count. It increases by one after each cycle in which `dev_cfg_evt` is high, and a device reset does not clear it.
- R11: Reads of write-only offsets (0x014, 0x024, 0x030, 0x038, 0x050, 0x064) and of unmapped offsets return zero.
- R12: `bus_rdata` takes the read value at the clock edge that samples `bus_rd` high, and holds it while `bus_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register byte offset |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, one cycle after the strobe |
| dev_used_evt | input | 1 | Device event: used ring updated |
| dev_cfg_evt | input | 1 | Device event: configuration changed |
| irq_o | output | 1 | Interrupt request, OR of status bits |
| notify_valid | output | 1 | One-cycle queue notification pulse |
| notify_qidx | output | 16 | Queue index carried by the notification |
| drv_features | output | 64 | Accepted feature bitmap |
| dev_status | output | 8 | Device status byte |
| dev_q_idx | input | 2 | Queue looked up by the device side |
| dev_q_ready | output | 1 | Ready flag of the looked-up queue |
| dev_q_size | output | 16 | Size of the looked-up queue |
| dev_q_desc | output | 64 | Descriptor table address |
| dev_q_avail | output | 64 | Available ring address |
| dev_q_used | output | 64 | Used ring address |

## Verification
Every register result except read data is due at the first clock edge after the stimulus. Bus writes and device events register there, so the bench samples stored state, `irq_o`, `drv_features`, `dev_status` and the `dev_q_*` outputs on the falling edge that follows. Read data lands on the edge that samples `bus_rd`. The read driver queues the expected word when it raises the strobe, and the monitor pops and compares it on the following falling edge. A notification is checked high on the falling edge right after its write and low one cycle later.

// File: rtl/pvdev_pkg.sv
package pvdev_pkg;
  localparam int ADDR_W = 8;
  typedef logic [ADDR_W-1:0] ofs_t;

  localparam ofs_t OFS_MAGIC     = 8'h00;
  localparam ofs_t OFS_VERSION   = 8'h04;
  localparam ofs_t OFS_DEVID     = 8'h08;
  localparam ofs_t OFS_VENDOR    = 8'h0C;
  localparam ofs_t OFS_DFEAT     = 8'h10;
  localparam ofs_t OFS_DFEAT_SEL = 8'h14;
  localparam ofs_t OFS_AFEAT     = 8'h20;
  localparam ofs_t OFS_AFEAT_SEL = 8'h24;
  localparam ofs_t OFS_QSEL      = 8'h30;
  localparam ofs_t OFS_QMAX      = 8'h34;
  localparam ofs_t OFS_QSIZE     = 8'h38;
  localparam ofs_t OFS_QREADY    = 8'h44;
  localparam ofs_t OFS_NOTIFY    = 8'h50;
  localparam ofs_t OFS_ISR       = 8'h60;
  localparam ofs_t OFS_IACK      = 8'h64;
  localparam ofs_t OFS_STATUS    = 8'h70;
  localparam ofs_t OFS_DESC_LO   = 8'h80;
  localparam ofs_t OFS_DESC_HI   = 8'h84;
  localparam ofs_t OFS_AVAIL_LO  = 8'h90;
  localparam ofs_t OFS_AVAIL_HI  = 8'h94;
  localparam ofs_t OFS_USED_LO   = 8'hA0;
  localparam ofs_t OFS_USED_HI   = 8'hA4;
  localparam ofs_t OFS_GEN       = 8'hFC;

  localparam logic [31:0] MAGIC_WORD = 32'h7472_6976;

  localparam int NUM_CAUSES = 2;
  localparam int CAUSE_USED = 0;
  localparam int CAUSE_CFG  = 1;

  typedef enum logic [3:0] {
    QF_NONE, QF_SEL, QF_MAX, QF_SIZE, QF_READY,
    QF_DESC_LO, QF_DESC_HI, QF_AVAIL_LO, QF_AVAIL_HI, QF_USED_LO, QF_USED_HI
  } qfield_e;
endpackage

// File: rtl/pvdev_feat_bank.sv
module pvdev_feat_bank
  import pvdev_pkg::*;
#(
  parameter int FEAT_SLICES = 2,
  parameter logic [FEAT_SLICES*32-1:0] DEV_FEATURES = '0,
  parameter int FSW = (FEAT_SLICES > 1) ? $clog2(FEAT_SLICES) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clr_i,
  input  logic                      dsel_wr_i,
  input  logic                      asel_wr_i,
  input  logic                      afeat_wr_i,
  input  logic [31:0]               wdata_i,
  output logic [31:0]               dev_slice_o,
  output logic [FEAT_SLICES*32-1:0] drv_feat_o
);
  logic [31:0] dsel_q, asel_q;
  logic        dsel_ok, asel_ok;
  logic [FEAT_SLICES-1:0][31:0] dev_w;
  logic [FEAT_SLICES-1:0][31:0] drv_w;

  assign dev_w   = DEV_FEATURES;
  assign dsel_ok = (dsel_q < 32'(FEAT_SLICES));
  assign asel_ok = (asel_q < 32'(FEAT_SLICES));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dsel_q <= '0;
      asel_q <= '0;
    end else begin
      if (dsel_wr_i) dsel_q <= wdata_i;
      if (asel_wr_i) asel_q <= wdata_i;
    end
  end

  assign dev_slice_o = dsel_ok ? dev_w[dsel_q[FSW-1:0]] : '0;

  for (genvar s = 0; s < FEAT_SLICES; s++) begin : g_slice
    logic hit;
    assign hit = afeat_wr_i && asel_ok && (asel_q[FSW-1:0] == FSW'(s));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      drv_w[s] <= '0;
      else if (clr_i)  drv_w[s] <= '0;
      else if (hit)    drv_w[s] <= wdata_i;
    end
  end

  assign drv_feat_o = drv_w;

  AST_DRV_OOR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (afeat_wr_i && !asel_ok && !clr_i) |=> $stable(drv_feat_o)); // R3
  AST_DRV_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (drv_feat_o == '0)); // R9
endmodule

// File: rtl/pvdev_queue_bank.sv
module pvdev_queue_bank
  import pvdev_pkg::*;
#(
  parameter int          NUM_QUEUES = 4,
  parameter int          QSZ_W      = 16,
  parameter int unsigned QUEUE_MAX  = 256,
  parameter int          DIDX_W     = (NUM_QUEUES > 1) ? $clog2(NUM_QUEUES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              wr_i,
  input  qfield_e           field_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic [DIDX_W-1:0] dev_idx_i,
  output logic              dev_ready_o,
  output logic [QSZ_W-1:0]  dev_size_o,
  output logic [63:0]       dev_desc_o,
  output logic [63:0]       dev_avail_o,
  output logic [63:0]       dev_used_o
);
  localparam int NHALF = 6;

  logic [31:0]       sel_q;
  logic              sel_ok;
  logic [DIDX_W-1:0] sel_idx;
  logic [NUM_QUEUES-1:0]                   ready_v;
  logic [NUM_QUEUES-1:0][QSZ_W-1:0]        size_v;
  logic [NUM_QUEUES-1:0][NHALF-1:0][31:0]  ring_v;

  assign sel_ok  = (sel_q < 32'(NUM_QUEUES));
  assign sel_idx = sel_q[DIDX_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          sel_q <= '0;
    else if (wr_i && field_i == QF_SEL)  sel_q <= wdata_i;
  end

  for (genvar q = 0; q < NUM_QUEUES; q++) begin : g_queue
    logic                       hit;
    logic                       rdy;
    logic [QSZ_W-1:0]           sz;
    logic [NHALF-1:0][31:0]     ring;

    assign hit = wr_i && sel_ok && (sel_idx == DIDX_W'(q));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rdy  <= 1'b0;
        sz   <= '0;
        ring <= '0;
      end else if (clr_i) begin
        rdy  <= 1'b0;
        sz   <= '0;
        ring <= '0;
      end else if (hit) begin
        case (field_i)
          QF_SIZE:     sz      <= wdata_i[QSZ_W-1:0];
          QF_READY:    rdy     <= wdata_i[0];
          QF_DESC_LO:  ring[0] <= wdata_i;
          QF_DESC_HI:  ring[1] <= wdata_i;
          QF_AVAIL_LO: ring[2] <= wdata_i;
          QF_AVAIL_HI: ring[3] <= wdata_i;
          QF_USED_LO:  ring[4] <= wdata_i;
          QF_USED_HI:  ring[5] <= wdata_i;
          default: ;
        endcase
      end
    end

    assign ready_v[q] = rdy;
    assign size_v[q]  = sz;
    assign ring_v[q]  = ring;
  end

  always_comb begin
    rdata_o = '0;
    if (sel_ok) begin
      case (field_i)
        QF_MAX:      rdata_o = 32'(QUEUE_MAX);
        QF_READY:    rdata_o = {31'b0, ready_v[sel_idx]};
        QF_DESC_LO:  rdata_o = ring_v[sel_idx][0];
        QF_DESC_HI:  rdata_o = ring_v[sel_idx][1];
        QF_AVAIL_LO: rdata_o = ring_v[sel_idx][2];
        QF_AVAIL_HI: rdata_o = ring_v[sel_idx][3];
        QF_USED_LO:  rdata_o = ring_v[sel_idx][4];
        QF_USED_HI:  rdata_o = ring_v[sel_idx][5];
        default: ;
      endcase
    end
  end

  assign dev_ready_o = ready_v[dev_idx_i];
  assign dev_size_o  = size_v[dev_idx_i];
  assign dev_desc_o  = {ring_v[dev_idx_i][1], ring_v[dev_idx_i][0]};
  assign dev_avail_o = {ring_v[dev_idx_i][3], ring_v[dev_idx_i][2]};
  assign dev_used_o  = {ring_v[dev_idx_i][5], ring_v[dev_idx_i][4]};

  AST_QUEUES_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (ready_v == '0 && size_v == '0)); // R9
  AST_OOR_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && !sel_ok && !clr_i && field_i != QF_SEL) |=>
      ($stable(ready_v) && $stable(size_v) && $stable(ring_v))); // R4
endmodule

// File: rtl/pvdev_irq.sv
module pvdev_irq
  import pvdev_pkg::*;
#(
  parameter int NC = NUM_CAUSES
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic [NC-1:0] set_i,
  input  logic          ack_i,
  input  logic [NC-1:0] ack_bits_i,
  output logic [NC-1:0] status_o,
  output logic          irq_o
);
  logic [NC-1:0] keep;

  assign keep = clr_i ? '0 : (status_o & ~(ack_i ? ack_bits_i : '0));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_o <= '0;
    else        status_o <= keep | set_i;
  end

  assign irq_o = |status_o;

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i != '0) |=> ((status_o & $past(set_i)) == $past(set_i))); // R7
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    ack_i |=> ((status_o & $past(ack_bits_i) & ~$past(set_i)) == '0)); // R7
endmodule

// File: rtl/pvdev_regfile.sv
module pvdev_regfile
  import pvdev_pkg::*;
#(
  parameter int          NUM_QUEUES   = 4,
  parameter int          FEAT_SLICES  = 2,
  parameter logic [FEAT_SLICES*32-1:0] DEV_FEATURES = 64'h0000_0001_8000_0035,
  parameter logic [31:0] VERSION      = 32'd2,
  parameter logic [31:0] DEVICE_ID    = 32'd1,
  parameter logic [31:0] VENDOR_ID    = 32'h0000_5AFE,
  parameter int          QSZ_W        = 16,
  parameter int unsigned QUEUE_MAX    = 256,
  parameter int          NIDX_W       = 16,
  parameter int          ST_W         = 8,
  parameter int          GEN_W        = 32,
  parameter int          DIDX_W       = (NUM_QUEUES > 1) ? $clog2(NUM_QUEUES) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic                      bus_wr,
  input  logic [31:0]               bus_wdata,
  input  logic                      bus_rd,
  output logic [31:0]               bus_rdata,
  input  logic                      dev_used_evt,
  input  logic                      dev_cfg_evt,
  output logic                      irq_o,
  output logic                      notify_valid,
  output logic [NIDX_W-1:0]         notify_qidx,
  output logic [FEAT_SLICES*32-1:0] drv_features,
  output logic [ST_W-1:0]           dev_status,
  input  logic [DIDX_W-1:0]         dev_q_idx,
  output logic                      dev_q_ready,
  output logic [QSZ_W-1:0]          dev_q_size,
  output logic [63:0]               dev_q_desc,
  output logic [63:0]               dev_q_avail,
  output logic [63:0]               dev_q_used
);
  qfield_e              qfield;
  logic [31:0]          q_rdata;
  logic [31:0]          dev_slice;
  logic [NUM_CAUSES-1:0] isr;
  logic [NUM_CAUSES-1:0] set_vec;
  logic [ST_W-1:0]      st_q;
  logic [GEN_W-1:0]     gen_q;
  logic                 dev_reset;
  logic                 nfy_hit;
  logic [31:0]          rd_word;

  // Queue field decode
  always_comb begin
    case (bus_addr)
      OFS_QSEL:     qfield = QF_SEL;
      OFS_QMAX:     qfield = QF_MAX;
      OFS_QSIZE:    qfield = QF_SIZE;
      OFS_QREADY:   qfield = QF_READY;
      OFS_DESC_LO:  qfield = QF_DESC_LO;
      OFS_DESC_HI:  qfield = QF_DESC_HI;
      OFS_AVAIL_LO: qfield = QF_AVAIL_LO;
      OFS_AVAIL_HI: qfield = QF_AVAIL_HI;
      OFS_USED_LO:  qfield = QF_USED_LO;
      OFS_USED_HI:  qfield = QF_USED_HI;
      default:      qfield = QF_NONE;
    endcase
  end

  assign dev_reset = bus_wr && (bus_addr == OFS_STATUS) && (bus_wdata == '0);
  assign nfy_hit   = bus_wr && (bus_addr == OFS_NOTIFY);

  pvdev_feat_bank #(
    .FEAT_SLICES (FEAT_SLICES),
    .DEV_FEATURES(DEV_FEATURES)
  ) u_feat (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_i      (dev_reset),
    .dsel_wr_i  (bus_wr && bus_addr == OFS_DFEAT_SEL),
    .asel_wr_i  (bus_wr && bus_addr == OFS_AFEAT_SEL),
    .afeat_wr_i (bus_wr && bus_addr == OFS_AFEAT),
    .wdata_i    (bus_wdata),
    .dev_slice_o(dev_slice),
    .drv_feat_o (drv_features)
  );

  pvdev_queue_bank #(
    .NUM_QUEUES(NUM_QUEUES),
    .QSZ_W     (QSZ_W),
    .QUEUE_MAX (QUEUE_MAX),
    .DIDX_W    (DIDX_W)
  ) u_queue (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_i      (dev_reset),
    .wr_i       (bus_wr),
    .field_i    (qfield),
    .wdata_i    (bus_wdata),
    .rdata_o    (q_rdata),
    .dev_idx_i  (dev_q_idx),
    .dev_ready_o(dev_q_ready),
    .dev_size_o (dev_q_size),
    .dev_desc_o (dev_q_desc),
    .dev_avail_o(dev_q_avail),
    .dev_used_o (dev_q_used)
  );

  always_comb begin
    set_vec             = '0;
    set_vec[CAUSE_USED] = dev_used_evt;
    set_vec[CAUSE_CFG]  = dev_cfg_evt;
  end

  pvdev_irq u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_i     (dev_reset),
    .set_i     (set_vec),
    .ack_i     (bus_wr && bus_addr == OFS_IACK),
    .ack_bits_i(bus_wdata[NUM_CAUSES-1:0]),
    .status_o  (isr),
    .irq_o     (irq_o)
  );

  // Device status, generation count, notification pulse
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q         <= '0;
      gen_q        <= '0;
      notify_valid <= 1'b0;
      notify_qidx  <= '0;
    end else begin
      if (bus_wr && bus_addr == OFS_STATUS) st_q <= bus_wdata[ST_W-1:0];
      if (dev_cfg_evt) gen_q <= gen_q + 1'b1;
      notify_valid <= nfy_hit;
      if (nfy_hit) notify_qidx <= bus_wdata[NIDX_W-1:0];
    end
  end

  assign dev_status = st_q;

  // Read mux
  always_comb begin
    case (bus_addr)
      OFS_MAGIC:   rd_word = MAGIC_WORD;
      OFS_VERSION: rd_word = VERSION;
      OFS_DEVID:   rd_word = DEVICE_ID;
      OFS_VENDOR:  rd_word = VENDOR_ID;
      OFS_DFEAT:   rd_word = dev_slice;
      OFS_ISR:     rd_word = 32'(isr);
      OFS_STATUS:  rd_word = 32'(st_q);
      OFS_GEN:     rd_word = 32'(gen_q);
      default:     rd_word = q_rdata;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_word;
  end

  AST_MAGIC_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == OFS_MAGIC) |=> (bus_rdata == MAGIC_WORD)); // R1
  AST_USED_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    dev_used_evt |=> irq_o); // R6
  AST_NOTIFY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    nfy_hit |=> (notify_valid && notify_qidx == $past(bus_wdata[NIDX_W-1:0]))); // R8
  AST_NOTIFY_ONESHOT: assert property (@(posedge clk) disable iff (!rst_n)
    !nfy_hit |=> !notify_valid); // R8
  AST_GEN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    dev_cfg_evt |=> (gen_q == $past(gen_q) + 1'b1)); // R10
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata)); // R12
endmodule

// File: tb/sim_pvdev_regfile.sv
module sim_pvdev_regfile;
  localparam int CLK_PERIOD = 10;
  localparam int NQ = 4;
  localparam logic [31:0] EXP_MAGIC = 32'h7472_6976;
  localparam logic [31:0] EXP_VER   = 32'd2;
  localparam logic [31:0] EXP_DEVID = 32'd1;
  localparam logic [31:0] EXP_VEND  = 32'h0000_5AFE;
  localparam logic [31:0] EXP_FEAT0 = 32'h8000_0035;
  localparam logic [31:0] EXP_FEAT1 = 32'h0000_0001;
  localparam logic [31:0] EXP_QMAX  = 32'd256;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic        dev_used_evt = 1'b0;
  logic        dev_cfg_evt = 1'b0;
  logic        irq_o;
  logic        notify_valid;
  logic [15:0] notify_qidx;
  logic [63:0] drv_features;
  logic [7:0]  dev_status;
  logic [1:0]  dev_q_idx = '0;
  logic        dev_q_ready;
  logic [15:0] dev_q_size;
  logic [63:0] dev_q_desc, dev_q_avail, dev_q_used;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  int gen_exp = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  pvdev_regfile u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .dev_used_evt(dev_used_evt), .dev_cfg_evt(dev_cfg_evt), .irq_o(irq_o),
    .notify_valid(notify_valid), .notify_qidx(notify_qidx),
    .drv_features(drv_features), .dev_status(dev_status),
    .dev_q_idx(dev_q_idx), .dev_q_ready(dev_q_ready), .dev_q_size(dev_q_size),
    .dev_q_desc(dev_q_desc), .dev_q_avail(dev_q_avail), .dev_q_used(dev_q_used)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  // driver side of the scoreboard: push expected read word
  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    bus_addr = a; bus_rd = 1'b1;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic pulse_used();
    dev_used_evt = 1'b1; @(negedge clk); dev_used_evt = 1'b0;
  endtask

  task automatic pulse_cfg();
    dev_cfg_evt = 1'b1; gen_exp++; @(negedge clk); dev_cfg_evt = 1'b0;
  endtask

  // monitor: read data due on the falling edge after the sampling edge
  initial begin
    forever begin
      @(posedge clk);
      if (rst_n && bus_rd === 1'b1) begin
        @(negedge clk);
        if (exp_q.size() == 0) chk("R12 unexpected read", 64'd1, 64'd0);
        else chk(tag_q.pop_front(), {32'b0, bus_rdata}, {32'b0, exp_q.pop_front()});
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R6 irq_o after reset", {63'b0, irq_o}, 64'd0);
    chk("R8 notify_valid after reset", {63'b0, notify_valid}, 64'd0);
    chk("R3 drv_features after reset", drv_features, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 identification
    rd(8'h00, EXP_MAGIC, "R1 magic");
    rd(8'h04, EXP_VER,   "R1 version");
    rd(8'h08, EXP_DEVID, "R1 device id");
    rd(8'h0C, EXP_VEND,  "R1 vendor id");
    wr(8'h00, 32'h0);
    wr(8'h08, 32'hFFFF_FFFF);
    rd(8'h00, EXP_MAGIC, "R1 magic after write");
    rd(8'h08, EXP_DEVID, "R1 device id after write");

    // R12 hold while idle
    @(negedge clk);
    chk("R12 rdata held", {32'b0, bus_rdata}, {32'b0, EXP_DEVID});

    // R2 device feature slices
    rd(8'h10, EXP_FEAT0, "R2 slice 0");
    wr(8'h14, 32'd1);
    rd(8'h10, EXP_FEAT1, "R2 slice 1");
    wr(8'h14, 32'd2);
    rd(8'h10, 32'h0, "R2 out-of-range slice");
    rd(8'h14, 32'h0, "R11 feature selector read");

    // R3 accepted features
    wr(8'h24, 32'd1);
    wr(8'h20, 32'hDEAD_0000);
    chk("R3 accepted slice 1", drv_features, 64'hDEAD_0000_0000_0000);
    wr(8'h24, 32'd0);
    wr(8'h20, 32'h0000_BEEF);
    chk("R3 accepted slice 0", drv_features, 64'hDEAD_0000_0000_BEEF);
    wr(8'h24, 32'd5);
    wr(8'h20, 32'hFFFF_FFFF);
    chk("R3 out-of-range ignored", drv_features, 64'hDEAD_0000_0000_BEEF);
    rd(8'h24, 32'h0, "R11 accepted selector read");

    // R4 / R5 queue setup
    for (int q = 0; q < NQ; q++) begin
      wr(8'h30, q);
      wr(8'h38, 32'd8 + q);
      wr(8'h44, q % 2);
      wr(8'h80, 32'h1000_0000 + q);
      wr(8'h84, 32'h0000_00A0 + q);
      wr(8'h90, 32'h2000_0000 + q);
      wr(8'h94, 32'h0000_00B0 + q);
      wr(8'hA0, 32'h3000_0000 + q);
      wr(8'hA4, 32'h0000_00C0 + q);
    end
    for (int q = 0; q < NQ; q++) begin
      wr(8'h30, q);
      rd(8'h34, EXP_QMAX, "R4 queue max");
      rd(8'h44, q % 2, "R4 queue ready");
      rd(8'h80, 32'h1000_0000 + q, "R4 desc low");
      rd(8'h84, 32'h0000_00A0 + q, "R4 desc high");
      rd(8'h90, 32'h2000_0000 + q, "R4 avail low");
      rd(8'h94, 32'h0000_00B0 + q, "R4 avail high");
      rd(8'hA0, 32'h3000_0000 + q, "R4 used low");
      rd(8'hA4, 32'h0000_00C0 + q, "R4 used high");
      rd(8'h38, 32'h0, "R5 size reads zero");
    end
    dev_q_idx = 2'd2;
    @(negedge clk);
    chk("R5 dev size q2", {48'b0, dev_q_size}, 64'd10);
    chk("R5 dev ready q2", {63'b0, dev_q_ready}, 64'd0);
    chk("R5 dev desc q2", dev_q_desc, 64'h0000_00A2_1000_0002);
    chk("R5 dev avail q2", dev_q_avail, 64'h0000_00B2_2000_0002);
    chk("R5 dev used q2", dev_q_used, 64'h0000_00C2_3000_0002);
    dev_q_idx = 2'd1;
    @(negedge clk);
    chk("R5 dev ready q1", {63'b0, dev_q_ready}, 64'd1);
    // out-of-range queue selector
    wr(8'h30, 32'd7);
    wr(8'h44, 32'd1);
    wr(8'h80, 32'h0000_0BAD);
    rd(8'h34, 32'h0, "R4 oor max");
    rd(8'h44, 32'h0, "R4 oor ready");
    rd(8'h80, 32'h0, "R4 oor desc");
    wr(8'h30, 32'd0);
    rd(8'h44, 32'h0, "R4 q0 ready untouched");
    rd(8'h80, 32'h1000_0000, "R4 q0 desc untouched");
    rd(8'h30, 32'h0, "R11 queue selector read");

    // R6 interrupts
    chk("R6 irq idle", {63'b0, irq_o}, 64'd0);
    pulse_used();
    chk("R6 irq after used event", {63'b0, irq_o}, 64'd1);
    rd(8'h60, 32'h1, "R6 status used");
    pulse_cfg();
    rd(8'h60, 32'h3, "R6 status both");

    // R7 acknowledge
    wr(8'h64, 32'h1);
    rd(8'h60, 32'h2, "R7 ack bit 0");
    bus_addr = 8'h64; bus_wdata = 32'h2; bus_wr = 1'b1;
    dev_cfg_evt = 1'b1; gen_exp++;
    @(negedge clk);
    bus_wr = 1'b0; dev_cfg_evt = 1'b0;
    rd(8'h60, 32'h2, "R7 set wins over ack");
    wr(8'h64, 32'h2);
    chk("R7 irq after full ack", {63'b0, irq_o}, 64'd0);
    rd(8'h60, 32'h0, "R7 status cleared");
    rd(8'h64, 32'h0, "R11 ack read");

    // R10 generation
    rd(8'hFC, gen_exp, "R10 generation");

    // R8 notification
    wr(8'h50, 32'h0001_0003);
    chk("R8 notify valid", {63'b0, notify_valid}, 64'd1);
    chk("R8 notify index", {48'b0, notify_qidx}, 64'd3);
    @(negedge clk);
    chk("R8 notify one cycle", {63'b0, notify_valid}, 64'd0);
    rd(8'h50, 32'h0, "R11 notify read");

    // R9 device status and device reset
    wr(8'h70, 32'h0F);
    chk("R9 dev_status", {56'b0, dev_status}, 64'h0F);
    rd(8'h70, 32'h0F, "R9 status read");
    pulse_used();
    wr(8'h70, 32'h0);
    rd(8'h70, 32'h0, "R9 status zero");
    chk("R9 irq cleared", {63'b0, irq_o}, 64'd0);
    chk("R9 features cleared", drv_features, 64'd0);
    chk("R9 dev ready cleared", {63'b0, dev_q_ready}, 64'd0);
    rd(8'h60, 32'h0, "R9 isr cleared");
    wr(8'h30, 32'd3);
    rd(8'hA4, 32'h0, "R9 ring cleared");
    rd(8'h44, 32'h0, "R9 ready cleared");
    dev_q_idx = 2'd3;
    @(negedge clk);
    chk("R9 size cleared", {48'b0, dev_q_size}, 64'd0);
    rd(8'hFC, gen_exp, "R10 generation survives reset");

    // R11 unmapped
    rd(8'hF0, 32'h0, "R11 unmapped F0");
    rd(8'h41, 32'h0, "R11 unaligned");

    repeat (2) @(negedge clk);
    chk("R12 scoreboard drained", exp_q.size(), 64'd0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule